// File: doc/BRIEF.md
# Atomic Bit-Clear Memory Unit

This block carries out an indivisible read-modify-write on one memory location. It clears bits in the stored value: the new value is the old value ANDed with the inverse of a request operand. It takes one request at a time over a valid/ready handshake. Each request carries a base-register value, a base index, a stack-pointer value, an operand, a size code, acquire and release flags, and a destination register index. The unit reads the location, writes back the cleared value, and answers with the original contents, zero-extended for register writeback.

The unit drives a single-port memory with a simple request/acknowledge protocol. A lock output is held from the moment the read is issued until the write is acknowledged, so the memory side can block every other requester for the whole exchange. Each phase carries an ordering attribute. A base index of 31 takes the address from the stack-pointer input. In that case the address must be 16-byte aligned, or the request ends with a fault and makes no memory access.

Top module: `atomic_clr_unit`

## Requirements
- R1: The write phase stores (old AND NOT operand), taking both values at the access width, so no bit that is set in the masked operand is set in the written data.
- R2: `rsp_data` equals the value read from memory before the modification, limited to the access width.
- R3: The access width in bytes is 1 shifted left by `req_size` (0 = 8 bits, 1 = 16, 2 = 32, 3 = 64). `mem_size` carries that code in both phases. For widths below 64, operand bits above the width have no effect on the stored result.
- R4: For size codes 0, 1 and 2, bits 63..32 of `rsp_data` are zero. Bits above the access width are also zero.
- R5: The read phase has `mem_ordered` = 1 only when `req_acq` = 1 and `req_dst` is not 31. Otherwise `mem_ordered` is 0.
- R6: The write phase has `mem_ordered` equal to `req_rel`.
- R7: When `req_dst` = 31, `rsp_wb_en` is 0 and the memory write still takes place. For any other index on a non-faulting request, `rsp_wb_en` is 1 and `rsp_dst` echoes the index.
- R8: When `req_base` = 31, `mem_addr` is `req_sp`. For any other index, `mem_addr` is `req_addr`.
- R9: When `req_base` = 31 and `req_sp[3:0]` is not zero, the response has `rsp_fault` = 1 and `rsp_wb_en` = 0, and no memory access is made.
- R10: A read precedes its write. `mem_lock` is 1 from the cycle the read is issued through the cycle the write is acknowledged. `req_ready` is 0 until the response has been given, and the response comes one cycle after the write acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Unit idle, request accepted on valid |
| req_addr | input | 64 | Base register value |
| req_base | input | 5 | Base register index, 31 selects stack pointer |
| req_sp | input | 64 | Stack-pointer value |
| req_operand | input | 64 | Bits to clear |
| req_size | input | 2 | Size code, width = 8 << code bits |
| req_acq | input | 1 | Acquire flag |
| req_rel | input | 1 | Release flag |
| req_dst | input | 5 | Destination register index, 31 = none |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | 64 | Memory byte address |
| mem_size | output | 2 | Access size code |
| mem_wdata | output | 64 | Write data, right-aligned |
| mem_ordered | output | 1 | Ordered attribute of the current phase |
| mem_lock | output | 1 | Exclusive hold of memory |
| mem_ack | input | 1 | Memory acknowledge |
| mem_rdata | input | 64 | Read data, right-aligned, valid with acknowledge |
| rsp_valid | output | 1 | Response valid, one cycle |
| rsp_fault | output | 1 | Stack-pointer alignment fault |
| rsp_wb_en | output | 1 | Register writeback enable |
| rsp_dst | output | 5 | Destination register index |
| rsp_data | output | 64 | Original memory value, zero-extended |

## Verification
The assertions assume a memory side that raises `mem_ack` for one cycle per request and holds it low in the cycle after. They also assume right-aligned `mem_rdata` that is valid together with the acknowledge. The bench memory model follows that protocol exactly. Requests are held stable only in their accept cycle, which the unit tolerates because it registers them. Addresses are kept inside a small window so that no access crosses an 8-byte word, and the memory model relies on that.

// File: rtl/aclr_pkg.sv
package aclr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2,
    ST_RESP  = 2'd3
  } aclr_state_e;
endpackage

// File: rtl/aclr_req.sv
module aclr_req #(
  parameter int ADDR_W   = 64,
  parameter int DATA_W   = 64,
  parameter int IDX_W    = 5,
  parameter int SP_ALIGN = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [IDX_W-1:0]  in_base,
  input  logic [ADDR_W-1:0] in_sp,
  input  logic [DATA_W-1:0] in_op,
  input  logic [1:0]        in_size,
  input  logic              in_acq,
  input  logic              in_rel,
  input  logic [IDX_W-1:0]  in_dst,
  output logic              fault_in,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] op_q,
  output logic [1:0]        size_q,
  output logic              acq_q,
  output logic              rel_q,
  output logic [IDX_W-1:0]  dst_q
);
  localparam int ALIGN_LSB = $clog2(SP_ALIGN);
  localparam logic [IDX_W-1:0] SP_IDX = {IDX_W{1'b1}};

  logic use_sp;
  assign use_sp   = (in_base == SP_IDX);
  assign fault_in = use_sp && (in_sp[ALIGN_LSB-1:0] != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      op_q   <= '0;
      size_q <= '0;
      acq_q  <= 1'b0;
      rel_q  <= 1'b0;
      dst_q  <= '0;
    end else if (accept) begin
      addr_q <= use_sp ? in_sp : in_addr;
      op_q   <= in_op;
      size_q <= in_size;
      acq_q  <= in_acq;
      rel_q  <= in_rel;
      dst_q  <= in_dst;
    end
  end

  AST_SP_ADDR_SEL: assert property (@(posedge clk) disable iff (rst)
    (accept && in_base == SP_IDX) |=> (addr_q == $past(in_sp))); // R8
  AST_REG_ADDR_SEL: assert property (@(posedge clk) disable iff (rst)
    (accept && in_base != SP_IDX) |=> (addr_q == $past(in_addr))); // R8
endmodule

// File: rtl/aclr_alu.sv
module aclr_alu #(
  parameter int DATA_W = 64
) (
  input  logic [1:0]        size,
  input  logic [DATA_W-1:0] rd_raw,
  input  logic [DATA_W-1:0] old_q,
  input  logic [DATA_W-1:0] op,
  output logic [DATA_W-1:0] old_masked,
  output logic [DATA_W-1:0] op_masked,
  output logic [DATA_W-1:0] result
);
  localparam int NBYTES = DATA_W / 8;

  logic [DATA_W-1:0] mask;

  for (genvar b = 0; b < NBYTES; b++) begin : g_lane
    logic lane_on;
    assign lane_on = (b < (1 << size));
    assign mask[b*8 +: 8] = {8{lane_on}};
  end

  assign old_masked = rd_raw & mask;
  assign op_masked  = op & mask;
  assign result     = old_q & ~op_masked;
endmodule

// File: rtl/aclr_ctrl.sv
module aclr_ctrl
  import aclr_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              fault_in,
  input  logic              acq_q,
  input  logic              rel_q,
  input  logic [IDX_W-1:0]  dst_q,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] old_masked,
  output logic              req_ready,
  output logic              accept,
  output logic              mem_req,
  output logic              mem_we,
  output logic              mem_ordered,
  output logic              mem_lock,
  output logic [DATA_W-1:0] old_q,
  output logic              rsp_valid,
  output logic              rsp_fault,
  output logic              rsp_wb_en
);
  localparam logic [IDX_W-1:0] ZR_IDX = {IDX_W{1'b1}};

  aclr_state_e state;
  logic        fault_q;

  assign req_ready   = (state == ST_IDLE);
  assign accept      = req_ready && req_valid;
  assign mem_req     = (state == ST_READ) || (state == ST_WRITE);
  assign mem_we      = (state == ST_WRITE);
  assign mem_lock    = mem_req;
  assign mem_ordered = (state == ST_WRITE) ? rel_q
                     : (acq_q && (dst_q != ZR_IDX));
  assign rsp_valid   = (state == ST_RESP);
  assign rsp_fault   = fault_q;
  assign rsp_wb_en   = !fault_q && (dst_q != ZR_IDX);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      fault_q <= 1'b0;
      old_q   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (req_valid) begin
          fault_q <= fault_in;
          old_q   <= '0;
          state   <= fault_in ? ST_RESP : ST_READ;
        end
        ST_READ: if (mem_ack) begin
          old_q <= old_masked;
          state <= ST_WRITE;
        end
        ST_WRITE: if (mem_ack) state <= ST_RESP;
        ST_RESP:  state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  AST_FAULT_NO_ACCESS: assert property (@(posedge clk) disable iff (rst)
    (accept && fault_in) |=> (rsp_valid && rsp_fault && !mem_req)); // R9
  AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_we && mem_ack) |=> (mem_req && mem_we && mem_lock)); // R10
  AST_WRITE_ACK_RESP: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we && mem_ack) |=> (rsp_valid && !mem_lock)); // R10
  AST_ACCEPT_LOCKS: assert property (@(posedge clk) disable iff (rst)
    (accept && !fault_in) |=> (mem_req && !mem_we && mem_lock && !req_ready)); // R10
endmodule

// File: rtl/atomic_clr_unit.sv
module atomic_clr_unit #(
  parameter int ADDR_W   = 64,
  parameter int DATA_W   = 64,
  parameter int IDX_W    = 5,
  parameter int SP_ALIGN = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [IDX_W-1:0]  req_base,
  input  logic [ADDR_W-1:0] req_sp,
  input  logic [DATA_W-1:0] req_operand,
  input  logic [1:0]        req_size,
  input  logic              req_acq,
  input  logic              req_rel,
  input  logic [IDX_W-1:0]  req_dst,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [1:0]        mem_size,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_ordered,
  output logic              mem_lock,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              rsp_valid,
  output logic              rsp_fault,
  output logic              rsp_wb_en,
  output logic [IDX_W-1:0]  rsp_dst,
  output logic [DATA_W-1:0] rsp_data
);
  localparam logic [IDX_W-1:0] ZR_IDX = {IDX_W{1'b1}};

  logic              accept, fault_in, acq_q, rel_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] op_q, old_q, old_masked, op_masked, result;
  logic [1:0]        size_q;
  logic [IDX_W-1:0]  dst_q;

  aclr_req #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .SP_ALIGN(SP_ALIGN)
  ) u_req (
    .clk(clk), .rst(rst), .accept(accept),
    .in_addr(req_addr), .in_base(req_base), .in_sp(req_sp),
    .in_op(req_operand), .in_size(req_size), .in_acq(req_acq),
    .in_rel(req_rel), .in_dst(req_dst), .fault_in(fault_in),
    .addr_q(addr_q), .op_q(op_q), .size_q(size_q), .acq_q(acq_q),
    .rel_q(rel_q), .dst_q(dst_q)
  );

  aclr_alu #(.DATA_W(DATA_W)) u_alu (
    .size(size_q), .rd_raw(mem_rdata), .old_q(old_q), .op(op_q),
    .old_masked(old_masked), .op_masked(op_masked), .result(result)
  );

  aclr_ctrl #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .fault_in(fault_in),
    .acq_q(acq_q), .rel_q(rel_q), .dst_q(dst_q), .mem_ack(mem_ack),
    .old_masked(old_masked), .req_ready(req_ready), .accept(accept),
    .mem_req(mem_req), .mem_we(mem_we), .mem_ordered(mem_ordered),
    .mem_lock(mem_lock), .old_q(old_q), .rsp_valid(rsp_valid),
    .rsp_fault(rsp_fault), .rsp_wb_en(rsp_wb_en)
  );

  assign mem_addr  = addr_q;
  assign mem_size  = size_q;
  assign mem_wdata = result;
  assign rsp_dst   = dst_q;
  assign rsp_data  = old_q;

  AST_CLEARED_BITS: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> ((mem_wdata & op_masked) == '0)); // R1
  AST_ACQ_ZR_PLAIN: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_we && dst_q == ZR_IDX) |-> !mem_ordered); // R5
  AST_REL_ATTR: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> (mem_ordered == rel_q)); // R6
  AST_ZR_NO_WB: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_dst == ZR_IDX) |-> !rsp_wb_en); // R7

  if (DATA_W > 32) begin : g_zext_chk
    AST_ZERO_EXTEND: assert property (@(posedge clk) disable iff (rst)
      (rsp_valid && rsp_size_small(size_q)) |-> (rsp_data[DATA_W-1:32] == '0)); // R4
  end

  function automatic logic rsp_size_small(input logic [1:0] s);
    return s != 2'b11;
  endfunction
endmodule

// File: tb/atomic_clr_unit_tb.sv
module atomic_clr_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_addr = '0, req_sp = '0, req_operand = '0;
  logic [4:0]  req_base = '0, req_dst = '0;
  logic [1:0]  req_size = '0;
  logic        req_acq = 1'b0, req_rel = 1'b0;
  logic        mem_req, mem_we, mem_ordered, mem_lock;
  logic [63:0] mem_addr, mem_wdata;
  logic [1:0]  mem_size;
  logic        mem_ack = 1'b0;
  logic [63:0] mem_rdata = '0;
  logic        rsp_valid, rsp_fault, rsp_wb_en;
  logic [4:0]  rsp_dst;
  logic [63:0] rsp_data;

  always #2.5 clk = ~clk;

  atomic_clr_unit u_dut (.*);

  typedef struct {
    logic        fault, wb, rd_ord, wr_ord;
    logic [4:0]  dst;
    logic [63:0] data, addr;
    int          nacc;
    logic [1:0]  size;
  } exp_t;

  exp_t        exp_q[$];
  logic [63:0] bmem [32];
  logic [63:0] model[32];
  int checks = 0, errors = 0, cycles = 0;

  logic        obs_rd_ord, obs_wr_ord, obs_lock_bad, obs_order_bad;
  logic [63:0] obs_addr;
  logic [1:0]  obs_size;
  int          obs_nacc = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // bench memory: one-cycle acknowledge, right-aligned data
  always @(posedge clk) begin
    if (rst) mem_ack <= 1'b0;
    else if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      if (!mem_lock) obs_lock_bad = 1'b1;
      if (mem_we) begin
        if (obs_nacc != 1) obs_order_bad = 1'b1;
        obs_wr_ord = mem_ordered;
        for (int b = 0; b < (1 << mem_size); b++)
          bmem[mem_addr[7:3]][(mem_addr[2:0] + b) * 8 +: 8] = mem_wdata[b*8 +: 8];
      end else begin
        if (obs_nacc != 0) obs_order_bad = 1'b1;
        obs_rd_ord = mem_ordered;
        obs_addr   = mem_addr;
        obs_size   = mem_size;
        mem_rdata <= bmem[mem_addr[7:3]] >> (mem_addr[2:0] * 8);
      end
      obs_nacc++;
    end else mem_ack <= 1'b0;
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      exp_t e;
      if (exp_q.size() == 0) chk(0, "R10 unexpected response", 1, 0);
      else begin
        e = exp_q.pop_front();
        chk(rsp_fault == e.fault, "R9 fault", rsp_fault, e.fault);
        chk(obs_nacc == e.nacc, "R9/R10 access count", obs_nacc, e.nacc);
        chk(rsp_wb_en == e.wb, "R7 writeback enable", rsp_wb_en, e.wb);
        if (e.wb) chk(rsp_dst == e.dst, "R7 destination", rsp_dst, e.dst);
        if (!e.fault) begin
          chk(rsp_data == e.data, "R2 returned data", rsp_data, e.data);
          if (e.size != 2'd3)
            chk(rsp_data[63:32] == 32'd0, "R4 zero extension", rsp_data, 0);
          chk(obs_addr == e.addr, "R8 address", obs_addr, e.addr);
          chk(obs_size == e.size, "R3 size code", obs_size, e.size);
          chk(obs_rd_ord == e.rd_ord, "R5 read ordering", obs_rd_ord, e.rd_ord);
          chk(obs_wr_ord == e.wr_ord, "R6 write ordering", obs_wr_ord, e.wr_ord);
          chk(!obs_lock_bad, "R10 lock held", obs_lock_bad, 0);
          chk(!obs_order_bad, "R10 read before write", obs_order_bad, 0);
        end
      end
      obs_nacc = 0; obs_lock_bad = 1'b0; obs_order_bad = 1'b0;
    end
  end

  task automatic issue(input logic [4:0] base, input logic [63:0] raddr,
                       input logic [63:0] sp, input logic [63:0] op,
                       input logic [1:0] sz, input logic acq, input logic rel,
                       input logic [4:0] dst);
    exp_t e;
    logic [63:0] a, mask, oldv, newv;
    a    = (base == 5'd31) ? sp : raddr;
    mask = (sz == 2'd3) ? '1 : ((64'd1 << (8 << sz)) - 64'd1);
    e.fault  = (base == 5'd31) && (sp[3:0] != 4'd0);
    oldv     = (model[a[7:3]] >> (a[2:0] * 8)) & mask;
    newv     = oldv & ~(op & mask);
    e.data   = oldv;
    e.addr   = a;
    e.size   = sz;
    e.dst    = dst;
    e.wb     = !e.fault && (dst != 5'd31);
    e.rd_ord = acq && (dst != 5'd31);
    e.wr_ord = rel;
    e.nacc   = e.fault ? 0 : 2;
    if (!e.fault)
      for (int b = 0; b < (1 << sz); b++)
        model[a[7:3]][(a[2:0] + b) * 8 +: 8] = newv[b*8 +: 8];
    exp_q.push_back(e);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_base = base; req_addr = raddr; req_sp = sp; req_operand = op;
    req_size = sz; req_acq = acq; req_rel = rel; req_dst = dst;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R10 busy after accept", req_ready, 0);
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    obs_lock_bad = 1'b0; obs_order_bad = 1'b0;
    obs_rd_ord = 1'b0; obs_wr_ord = 1'b0; obs_addr = '0; obs_size = '0;
    for (int i = 0; i < 32; i++) begin
      bmem[i]  = 64'hF0E1_D2C3_B4A5_9687 ^ (64'(i) * 64'h0101_0303_0707_0F0F);
      model[i] = bmem[i];
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready, "R10 reset ready", req_ready, 1);
    chk(!rsp_valid && !mem_req && !mem_lock, "R10 reset idle",
        {rsp_valid, mem_req, mem_lock}, 0);

    issue(5'd4, 64'h10, 64'h0, 64'h0F0F_0000_FFFF_0001, 2'd3, 1, 0, 5'd3);   // R1 R2 R5
    issue(5'd4, 64'h20, 64'h0, 64'hFFFF_FFFF_0000_00FF, 2'd2, 1, 1, 5'd31);  // R4 R5 R6 R7
    issue(5'd2, 64'h29, 64'h0, 64'hFFFF_FFFF_FFFF_FF0F, 2'd0, 0, 0, 5'd9);   // R3 byte
    issue(5'd2, 64'h32, 64'h0, 64'hABCD_0000_1234_8001, 2'd1, 0, 1, 5'd7);   // R3 half
    issue(5'd31, 64'h08, 64'h40, 64'h00FF_00FF_00FF_00FF, 2'd3, 1, 1, 5'd1); // R8 sp
    issue(5'd31, 64'h08, 64'h48, 64'hFFFF, 2'd3, 1, 1, 5'd2);                // R9 fault
    issue(5'd31, 64'h08, 64'h44, 64'hFFFF, 2'd2, 0, 0, 5'd31);               // R9 fault
    issue(5'd5, 64'h50, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 2'd3, 0, 1, 5'd0);   // R1 all cleared
    issue(5'd5, 64'h50, 64'h0, 64'h0, 2'd3, 1, 0, 5'd12);                    // R2 reads zero
    issue(5'd6, 64'h60, 64'h0, 64'h0, 2'd2, 1, 0, 5'd30);                    // R1 unchanged
    issue(5'd0, 64'h10, 64'h0, 64'h8000_0000_0000_0000, 2'd3, 0, 0, 5'd31);  // R7 no wb, mem update

    repeat (3) @(negedge clk);
    for (int i = 0; i < 32; i++)
      chk(bmem[i] == model[i], "R1/R3/R7 memory contents", bmem[i], model[i]);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule